// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital state machine that governs a single-wire LIN bus transceiver that also carries an on-chip supply regulator. It samples three pins from the protocol controller: an enable, a standby select and the transmit data line. It also takes logic-level flags from the analog side: power-on reset, battery undervoltage, local and bus wake detection, and over-temperature. From these inputs it decides which of five states the part is in: powered off, standby, normal operation with the standard slope, normal operation with the reduced slope, or sleep.

In each state the controller drives the enables of the bus driver, the bus termination, the regulator and the slope selector. It also drives the inhibit output and chooses what the receive data pin shows. The analog driver, comparator, regulator and thresholds are outside the block. Each of them appears here only as a flag or an enable.

The slope of a normal session is fixed by the transmit line level at the moment the enable rises. While in standby, the receive pin tells the host whether the part was woken from the bus.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While porActive is high the mode is OFF (modeState 0) and regEnable, txEnable, termEnable and inhOn are low. Once porActive is low and batUnderVolt is low, the mode moves from OFF to STANDBY (modeState 1) with regEnable high and rxdSel HIGH (1).
- R2: In STANDBY, a synchronized rising edge of enPin while txdPin is high enters normal standard slope (modeState 2). In that mode txEnable and termEnable are high, slowSlope is low and rxdSel is BUS (0).
- R3: In STANDBY, a synchronized rising edge of enPin while txdPin is low enters normal reduced slope (modeState 3) with slowSlope high. txEnable stays low until txdPin is next seen high.
- R4: In either normal mode, a synchronized falling edge of enPin goes to STANDBY if stbPin is high and to SLEEP (modeState 4) if stbPin is low. txEnable drops in the same cycle as the mode change.
- R5: inhOn is high in a normal mode only if stbPin was high at the entry transition. It is low in every other mode.
- R6: In OFF, STANDBY and SLEEP, txEnable and termEnable are low.
- R7: regEnable is low in SLEEP and OFF and high in STANDBY and both normal modes, unless overTemp is set.
- R8: In SLEEP, a busWake or localWake pulse moves the mode to STANDBY. If both arrive together, the bus wake takes priority.
- R9: In STANDBY, rxdSel is LOW (2) after a bus wake, whether it arrived in SLEEP or in STANDBY, until a normal mode is entered. After power-up or a local wake it is HIGH (1).
- R10: In a normal mode, once the synchronized txdPin has been low for DOM_LIMIT consecutive cycles, txEnable is forced low. It stays low until txdPin is seen high again.
- R11: In a normal mode, batUnderVolt forces txEnable low without changing the mode.
- R12: While overTemp is high, txEnable and regEnable are both low.
- R13: enPin, stbPin and txdPin pass through a two-flop synchronizer. An enPin change driven before clock edge k changes modeState at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enPin | input | 1 | Enable pin from the protocol controller |
| stbPin | input | 1 | Standby select pin |
| txdPin | input | 1 | Transmit data pin, low means dominant |
| porActive | input | 1 | Power-on reset flag, high while supply is not valid |
| batUnderVolt | input | 1 | Battery undervoltage flag |
| localWake | input | 1 | Local wake event flag from the wake input detector |
| busWake | input | 1 | Bus wake event flag from the bus wake detector |
| overTemp | input | 1 | Over-temperature flag |
| txEnable | output | 1 | Bus driver enable, low keeps the bus recessive |
| termEnable | output | 1 | Bus termination resistor enable |
| regEnable | output | 1 | Supply regulator enable |
| slowSlope | output | 1 | Reduced slope select for the driver |
| inhOn | output | 1 | Inhibit output driven high when set, floating otherwise |
| rxdSel | output | 2 | Receive pin source: 0 bus data, 1 pulled high, 2 driven low |
| modeState | output | 3 | Current mode: 0 off, 1 standby, 2 normal standard, 3 normal reduced, 4 sleep |

## Verification
The bench times the synchronizer latency exactly. A design with one flop too few or too many would change the mode a cycle early or late. It enters reduced slope with transmit data held low, so a controller that enables the driver at once would put a dominant level on the bus. It holds transmit data low across the dominant timeout and checks both sides of that window, which catches a lock that never engages or never releases. It also follows the receive-pin wake flag through bus and local wakes, simultaneous wakes, and a later normal session. Any of these would expose a flag that is never cleared, a wrong priority, or a wake source that is lost.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_STBY  = 3'd1,
    MODE_FAST  = 3'd2,
    MODE_SLOW  = 3'd3,
    MODE_SLEEP = 3'd4
  } modeT;

  localparam logic [1:0] RXD_BUS  = 2'd0;
  localparam logic [1:0] RXD_HIGH = 2'd1;
  localparam logic [1:0] RXD_LOW  = 2'd2;

  // pin events from the datapath towards the control
  typedef struct packed {
    logic enRise;
    logic enFall;
    logic stbLvl;
    logic txdLvl;
  } pinEvtT;

  // strobes from the control towards the datapath
  typedef struct packed {
    logic enterNormal;
    logic enterSlow;
    logic leaveNormal;
    logic wakeBus;
    logic clearWake;
  } strobeT;

endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  input  logic [WIDTH-1:0] resetVal,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{resetVal[b]}};
      else       chain <= {chain[STAGES-2:0], rawIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/lin_mode_dp.sv
module lin_mode_dp
  import lin_mode_pkg::*;
#(
  parameter int DOM_LIMIT = 300000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enPin,
  input  logic        stbPin,
  input  logic        txdPin,
  input  logic        batUnderVolt,
  input  logic        overTemp,
  input  modeT        mode,
  input  strobeT      strobe,
  output pinEvtT      pinEvt,
  output logic        txEnable,
  output logic        termEnable,
  output logic        regEnable,
  output logic        slowSlope,
  output logic        inhOn,
  output logic [1:0]  rxdSel
);

  localparam int CNT_W = $clog2(DOM_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DOM_LIMIT);

  logic [2:0] pinSync;
  logic       enPrev;
  logic       enLvl;
  logic       inhLatch;
  logic       waitHigh;
  logic       busWoke;
  logic [CNT_W-1:0] domCnt;
  logic       domLock;
  logic       inNormal;

  // bit 2 enable, bit 1 standby select, bit 0 transmit data (idle high)
  lin_pin_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({enPin, stbPin, txdPin}),
    .resetVal(3'b001),
    .syncOut (pinSync)
  );

  assign enLvl = pinSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enLvl;
  end

  assign pinEvt.enRise = enLvl & ~enPrev;
  assign pinEvt.enFall = ~enLvl & enPrev;
  assign pinEvt.stbLvl = pinSync[1];
  assign pinEvt.txdLvl = pinSync[0];

  assign inNormal = (mode == MODE_FAST) || (mode == MODE_SLOW);

  // inhibit decision taken once, at the entry transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    inhLatch <= 1'b0;
    else if (strobe.enterNormal)  inhLatch <= pinEvt.stbLvl;
    else if (strobe.leaveNormal)  inhLatch <= 1'b0;
  end

  // reduced slope entry waits for the first recessive transmit level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    waitHigh <= 1'b0;
    else if (strobe.enterNormal)  waitHigh <= strobe.enterSlow;
    else if (pinEvt.txdLvl)       waitHigh <= 1'b0;
  end

  // wake source memory shown on the receive pin in standby
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   busWoke <= 1'b0;
    else if (strobe.clearWake)   busWoke <= 1'b0;
    else if (strobe.wakeBus)     busWoke <= 1'b1;
  end

  // dominant timeout: saturating count of low transmit cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            domCnt <= '0;
    else if (!inNormal || pinEvt.txdLvl)  domCnt <= '0;
    else if (domCnt != CNT_MAX)           domCnt <= domCnt + 1'b1;
  end

  assign domLock = (domCnt == CNT_MAX);

  assign txEnable   = inNormal & ~waitHigh & ~domLock & ~batUnderVolt & ~overTemp;
  assign termEnable = inNormal;
  assign regEnable  = (mode != MODE_OFF) && (mode != MODE_SLEEP) && !overTemp;
  assign slowSlope  = (mode == MODE_SLOW);
  assign inhOn      = inNormal & inhLatch;

  always_comb begin
    if (inNormal)                          rxdSel = RXD_BUS;
    else if (mode == MODE_STBY && busWoke) rxdSel = RXD_LOW;
    else                                   rxdSel = RXD_HIGH;
  end

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   porActive,
  input  logic   batUnderVolt,
  input  logic   localWake,
  input  logic   busWake,
  input  pinEvtT pinEvt,
  output modeT   mode,
  output strobeT strobe
);

  modeT modeNext;

  always_comb begin
    modeNext = mode;
    strobe   = '0;
    unique case (mode)
      MODE_OFF: begin
        if (!batUnderVolt) begin
          modeNext         = MODE_STBY;
          strobe.clearWake = 1'b1;
        end
      end
      MODE_STBY: begin
        if (pinEvt.enRise) begin
          modeNext           = pinEvt.txdLvl ? MODE_FAST : MODE_SLOW;
          strobe.enterNormal = 1'b1;
          strobe.enterSlow   = ~pinEvt.txdLvl;
          strobe.clearWake   = 1'b1;
        end else if (busWake) begin
          strobe.wakeBus = 1'b1;
        end
      end
      MODE_FAST, MODE_SLOW: begin
        if (pinEvt.enFall) begin
          modeNext           = pinEvt.stbLvl ? MODE_STBY : MODE_SLEEP;
          strobe.leaveNormal = 1'b1;
        end
      end
      MODE_SLEEP: begin
        if (busWake) begin
          modeNext       = MODE_STBY;
          strobe.wakeBus = 1'b1;
        end else if (localWake) begin
          modeNext         = MODE_STBY;
          strobe.clearWake = 1'b1;
        end
      end
      default: modeNext = MODE_OFF;
    endcase
    if (porActive) begin
      modeNext           = MODE_OFF;
      strobe             = '0;
      strobe.leaveNormal = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_OFF;
    else       mode <= modeNext;
  end

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int DOM_LIMIT = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       stbPin,
  input  logic       txdPin,
  input  logic       porActive,
  input  logic       batUnderVolt,
  input  logic       localWake,
  input  logic       busWake,
  input  logic       overTemp,
  output logic       txEnable,
  output logic       termEnable,
  output logic       regEnable,
  output logic       slowSlope,
  output logic       inhOn,
  output logic [1:0] rxdSel,
  output logic [2:0] modeState
);

  modeT   mode;
  strobeT strobe;
  pinEvtT pinEvt;

  lin_mode_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .porActive   (porActive),
    .batUnderVolt(batUnderVolt),
    .localWake   (localWake),
    .busWake     (busWake),
    .pinEvt      (pinEvt),
    .mode        (mode),
    .strobe      (strobe)
  );

  lin_mode_dp #(.DOM_LIMIT(DOM_LIMIT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enPin       (enPin),
    .stbPin      (stbPin),
    .txdPin      (txdPin),
    .batUnderVolt(batUnderVolt),
    .overTemp    (overTemp),
    .mode        (mode),
    .strobe      (strobe),
    .pinEvt      (pinEvt),
    .txEnable    (txEnable),
    .termEnable  (termEnable),
    .regEnable   (regEnable),
    .slowSlope   (slowSlope),
    .inhOn       (inhOn),
    .rxdSel      (rxdSel)
  );

  assign modeState = mode;

endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk
  import lin_mode_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       overTemp,
  input logic       txEnable,
  input logic       termEnable,
  input logic       regEnable,
  input logic       slowSlope,
  input logic       inhOn,
  input logic [1:0] rxdSel,
  input logic [2:0] modeState
);

  logic quietMode;
  assign quietMode = (modeState == 3'd0) || (modeState == 3'd1) || (modeState == 3'd4);

  a_r3_slow_entry_tx_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slowSlope) |-> !txEnable);

  a_r6_quiet_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    quietMode |-> (!txEnable && !termEnable));

  a_r12_overtemp_off: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |-> (!txEnable && !regEnable));

  a_r5_inh_normal_only: assert property (@(posedge clk) disable iff (!rstN)
    inhOn |-> (modeState == 3'd2 || modeState == 3'd3));

  a_r8_sleep_exit_path: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == 3'd4) |=> (modeState == 3'd4 || modeState == 3'd1 || modeState == 3'd0));

  a_r9_rxd_low_standby: assert property (@(posedge clk) disable iff (!rstN)
    (rxdSel == RXD_LOW) |-> (modeState == 3'd1));

endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (.*);

// File: tb/tb_lin_mode_ctrl.sv
module tb_lin_mode_ctrl;

  localparam int DOM = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 1'b0, stbPin = 1'b1, txdPin = 1'b1;
  logic porActive = 1'b1, batUnderVolt = 1'b0;
  logic localWake = 1'b0, busWake = 1'b0, overTemp = 1'b0;
  logic txEnable, termEnable, regEnable, slowSlope, inhOn;
  logic [1:0] rxdSel;
  logic [2:0] modeState;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lin_mode_ctrl #(.DOM_LIMIT(DOM)) dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_power_up;
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R1 off mode", modeState, 0);
    check("R1 off reg", regEnable, 0);
    check("R1 off tx", txEnable, 0);
    porActive = 1'b0;
    tick(3);
    check("R1 standby mode", modeState, 1);
    check("R7 standby reg", regEnable, 1);
    check("R9 power-up rxd high", rxdSel, 1);
    check("R6 standby tx", txEnable, 0);
    check("R6 standby term", termEnable, 0);
  endtask

  task automatic test_fast_entry;
    stbPin = 1'b1; txdPin = 1'b1;
    tick(3);
    enPin = 1'b1;
    tick(2);
    check("R13 not yet", modeState, 1);
    tick(1);
    check("R13 R2 fast mode", modeState, 2);
    check("R2 tx on", txEnable, 1);
    check("R2 term on", termEnable, 1);
    check("R2 slope", slowSlope, 0);
    check("R2 rxd bus", rxdSel, 0);
    check("R5 inh on", inhOn, 1);
  endtask

  task automatic test_dom_timeout;
    txdPin = 1'b0;
    tick(20);
    check("R10 before limit", txEnable, 1);
    tick(40);
    check("R10 locked", txEnable, 0);
    txdPin = 1'b1;
    tick(4);
    check("R10 released", txEnable, 1);
  endtask

  task automatic test_bat_uv;
    batUnderVolt = 1'b1;
    tick(2);
    check("R11 tx off", txEnable, 0);
    check("R11 mode kept", modeState, 2);
    batUnderVolt = 1'b0;
    tick(2);
    check("R11 tx back", txEnable, 1);
  endtask

  task automatic test_over_temp;
    overTemp = 1'b1;
    tick(2);
    check("R12 tx off", txEnable, 0);
    check("R12 reg off", regEnable, 0);
    overTemp = 1'b0;
    tick(2);
    check("R12 reg back", regEnable, 1);
  endtask

  task automatic test_fall_to_sleep;
    stbPin = 1'b0;
    enPin = 1'b0;
    tick(5);
    check("R4 sleep mode", modeState, 4);
    check("R4 tx off", txEnable, 0);
    check("R6 sleep term", termEnable, 0);
    check("R7 sleep reg", regEnable, 0);
    check("R5 sleep inh", inhOn, 0);
  endtask

  task automatic test_local_wake;
    localWake = 1'b1;
    tick(1);
    localWake = 1'b0;
    tick(2);
    check("R8 local wake mode", modeState, 1);
    check("R9 local wake rxd", rxdSel, 1);
  endtask

  task automatic test_slow_entry;
    stbPin = 1'b0; txdPin = 1'b0;
    tick(3);
    enPin = 1'b1;
    tick(5);
    check("R3 slow mode", modeState, 3);
    check("R3 slope", slowSlope, 1);
    check("R3 tx held", txEnable, 0);
    check("R5 inh floating", inhOn, 0);
    txdPin = 1'b1;
    tick(4);
    check("R3 tx after high", txEnable, 1);
  endtask

  task automatic test_fall_to_standby;
    stbPin = 1'b1;
    tick(3);
    enPin = 1'b0;
    tick(5);
    check("R4 standby mode", modeState, 1);
    check("R4 tx off", txEnable, 0);
    check("R7 reg on", regEnable, 1);
  endtask

  task automatic test_bus_wake_standby;
    busWake = 1'b1;
    tick(1);
    busWake = 1'b0;
    tick(2);
    check("R9 bus wake rxd low", rxdSel, 2);
    check("R9 still standby", modeState, 1);
    txdPin = 1'b1;
    enPin = 1'b1;
    tick(5);
    check("R9 normal rxd bus", rxdSel, 0);
    enPin = 1'b0;
    tick(5);
    check("R9 flag cleared", rxdSel, 1);
  endtask

  task automatic test_bus_wake_sleep;
    stbPin = 1'b0;
    enPin = 1'b1;
    tick(5);
    enPin = 1'b0;
    tick(5);
    check("R4 sleep again", modeState, 4);
    busWake = 1'b1; localWake = 1'b1;
    tick(1);
    busWake = 1'b0; localWake = 1'b0;
    tick(2);
    check("R8 both wake mode", modeState, 1);
    check("R8 R9 bus priority", rxdSel, 2);
  endtask

  task automatic test_por;
    porActive = 1'b1;
    tick(2);
    check("R1 por mode", modeState, 0);
    check("R1 por reg", regEnable, 0);
    check("R1 por inh", inhOn, 0);
  endtask

  initial begin
    test_power_up();
    test_fast_entry();
    test_dom_timeout();
    test_bat_uv();
    test_over_temp();
    test_fall_to_sleep();
    test_local_wake();
    test_slow_entry();
    test_fall_to_standby();
    test_bus_wake_standby();
    test_bus_wake_sleep();
    test_por();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule